// File: doc/BRIEF.md
# Raster Timing Generator for Parallel RGB Panels

This block runs on the pixel clock and produces the scan timing for a parallel RGB panel. A horizontal counter steps through the pixels of a line. A vertical counter steps through the lines of a frame. From these two counts the block decodes the horizontal and vertical sync strobes, a data-enable strobe and a zero-based coordinate for the pixel being shown.

During the visible window, the pixel word supplied by an upstream source is passed to the panel. Elsewhere, a programmable blank color is sent instead.

Geometry is supplied as packed 32-bit words, each holding a vertical and a horizontal quantity. A small control word carries the panel enable and one inversion bit for each strobe. The geometry and polarity words are copied into shadow registers at the end of each frame, so software may rewrite them at any time without tearing the frame in progress. The enable bit takes effect at once.

Top module: `raster_timing_gen`

## Requirements
- R1: Each geometry word (`cfg_total`, `cfg_active`, `cfg_hporch`, `cfg_vporch`) carries the vertical quantity in bits 31:16 and the horizontal quantity in bits 15:0.
- R2: A line lasts exactly `cfg_total[15:0]` pixel clocks. Pixel 0 is the sync pixel (one pixel wide). It is followed by `cfg_hporch[15:0]` leading porch pixels, then `cfg_active[15:0]` active pixels. The remainder of the total forms the trailing porch; `cfg_hporch[31:16]` names it but is not decoded.
- R3: A frame lasts exactly `cfg_total[31:16]` lines. Line 0 is the sync line (one line). It is followed by `cfg_vporch[15:0]` leading porch lines, then `cfg_active[31:16]` active lines. The remaining lines form the trailing porch.
- R4: `de` is asserted only on pixels that are active both horizontally and vertically. There, `pix_x` and `pix_y` give the zero-based position inside the active window; elsewhere both are 0.
- R5: While enabled, `rgb_out` equals `pix_in` when `de` is asserted and equals `cfg_blank` otherwise.
- R6: Strobes are active high by default. `cfg_ctrl` bit 2 inverts `hsync`, bit 3 inverts `vsync` and bit 4 inverts `de`.
- R7: With `cfg_ctrl` bit 0 low, the counters are held at zero. `hsync`, `vsync` and `de` sit at their inactive levels under the programmed polarity. `rgb_out`, `pix_x`, `pix_y` and `frame_start` are 0, and `frame_cnt` holds its value.
- R8: `frame_start` is high for one clock on pixel 0 of line 0. `frame_cnt` rises by one on the following clock and wraps modulo 2^FC_W.
- R9: While enabled, changes to geometry, blank color or polarity bits take effect from the first pixel of the next frame. While disabled, they are taken up continuously. Setting the enable bit starts output at pixel 0 of line 0 in the same clock.
- R10: After reset, `frame_cnt` is 0 and the block is idle with active-high polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_total | input | 32 | Total lines (31:16) and total pixels per line (15:0) |
| cfg_active | input | 32 | Active lines (31:16) and active pixels (15:0) |
| cfg_hporch | input | 32 | Trailing (31:16) and leading (15:0) horizontal porch |
| cfg_vporch | input | 32 | Trailing (31:16) and leading (15:0) vertical porch |
| cfg_blank | input | 24 | Color sent outside the active window |
| cfg_ctrl | input | 5 | Bit 0 enable; bits 2, 3, 4 invert hsync, vsync, de |
| pix_in | input | 24 | Pixel data from the upstream source |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | 16 | Active-window column |
| pix_y | output | 16 | Active-window row |
| rgb_out | output | 24 | Pixel data to the panel |
| frame_start | output | 1 | One-clock pulse at the start of each frame |
| frame_cnt | output | 16 | Frame counter |

## Verification
Every pixel clock of each run is compared with an arithmetic model of the line and frame position. The runs use four timings:
- A small frame whose trailing porch is longer than its leading porch. This separates a swapped porch field from a correct one and exposes off-by-one errors at the window edges.
- A minimal frame with zero porches and all strobes inverted. This exposes window comparisons that are one pixel too wide or too narrow, and any polarity bit wired to the wrong strobe.
- A switch from the first timing to the second in the middle of a frame. This shows whether the shadow copy is loaded exactly at the frame boundary; the frame counter is run through its wrap.
- A full-size frame with 240×320 active pixels. This exercises counts above eight bits.

The pixel input changes on every clock, so pass-through and blank substitution cannot be confused.

// File: rtl/raster_pkg.sv
`timescale 1ns/1ps
package raster_pkg;
  // control word layout
  localparam int CTRL_W      = 5;
  localparam int CTRL_EN     = 0;
  localparam int CTRL_HS_INV = 2;
  localparam int CTRL_VS_INV = 3;
  localparam int CTRL_DE_INV = 4;

  // axis indices for the counter/window pairs
  localparam int AXES = 2;
  localparam int AX_H = 0;
  localparam int AX_V = 1;

  typedef struct packed {
    logic de_inv;
    logic vs_inv;
    logic hs_inv;
  } pol_t;
endpackage

// File: rtl/raster_shadow.sv
`timescale 1ns/1ps
module raster_shadow
  import raster_pkg::*;
#(
  parameter int CW    = 16,
  parameter int RGB_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CW-1:0]    h_total_i,
  input  logic [CW-1:0]    h_act_i,
  input  logic [CW-1:0]    h_lead_i,
  input  logic [CW-1:0]    v_total_i,
  input  logic [CW-1:0]    v_act_i,
  input  logic [CW-1:0]    v_lead_i,
  input  logic [RGB_W-1:0] blank_i,
  input  pol_t             pol_i,
  output logic [CW-1:0]    h_total_o,
  output logic [CW-1:0]    h_act_o,
  output logic [CW-1:0]    h_lead_o,
  output logic [CW-1:0]    v_total_o,
  output logic [CW-1:0]    v_act_o,
  output logic [CW-1:0]    v_lead_o,
  output logic [RGB_W-1:0] blank_o,
  output pol_t             pol_o
);
  localparam int POL_W = $bits(pol_t);
  localparam int SW    = 6 * CW + RGB_W + POL_W;

  logic [SW-1:0] sh_q;
  logic [SW-1:0] sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load) begin
      sh_d = {h_total_i, h_act_i, h_lead_i, v_total_i, v_act_i, v_lead_i, blank_i, pol_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (load) begin
      sh_q <= sh_d;
    end
  end

  assign {h_total_o, h_act_o, h_lead_o, v_total_o, v_act_o, v_lead_o, blank_o, pol_o} = sh_q;
endmodule

// File: rtl/raster_axis_counter.sv
`timescale 1ns/1ps
module raster_axis_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic [CW-1:0] total,
  output logic [CW-1:0] cnt,
  output logic          last
);
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // wrap when the next count would reach the total (also covers total == 0)
  always_comb begin
    last   = ({1'b0, cnt} + 1'b1) >= {1'b0, total};
    cnt_en = clear | step;
    cnt_d  = cnt;
    if (clear) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = last ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

  AST_AXIS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && total != '0) |-> (cnt < total)); // R2

  AST_AXIS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last && !clear) |=> (cnt == '0)); // R3
endmodule

// File: rtl/raster_window.sv
`timescale 1ns/1ps
module raster_window #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] lead,
  input  logic [CW-1:0] act,
  output logic          sync,
  output logic          active,
  output logic [CW-1:0] coord
);
  logic [CW:0] first_act;
  logic [CW:0] last_act;

  always_comb begin
    first_act = {1'b0, lead} + 1'b1;
    last_act  = {1'b0, lead} + {1'b0, act};
    sync      = (cnt == '0);
    active    = ({1'b0, cnt} >= first_act) && ({1'b0, cnt} <= last_act);
    coord     = active ? CW'(cnt - lead - 1'b1) : '0;
  end
endmodule

// File: rtl/raster_timing_gen.sv
`timescale 1ns/1ps
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int CW    = 16,
  parameter int RGB_W = 24,
  parameter int FC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*CW-1:0]   cfg_total,
  input  logic [2*CW-1:0]   cfg_active,
  input  logic [2*CW-1:0]   cfg_hporch,
  input  logic [2*CW-1:0]   cfg_vporch,
  input  logic [RGB_W-1:0]  cfg_blank,
  input  logic [CTRL_W-1:0] cfg_ctrl,
  input  logic [RGB_W-1:0]  pix_in,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [CW-1:0]     pix_x,
  output logic [CW-1:0]     pix_y,
  output logic [RGB_W-1:0]  rgb_out,
  output logic              frame_start,
  output logic [FC_W-1:0]   frame_cnt
);
  localparam int W2 = 2 * CW;

  // the trailing porch fields are implied by the totals; bit 1 has no role here
  logic unused_cfg;
  assign unused_cfg = ^{cfg_hporch[W2-1:CW], cfg_vporch[W2-1:CW], cfg_ctrl[1]};

  logic en;
  pol_t pol_live;
  pol_t pol_sh;
  logic frame_end;
  logic shadow_load;

  logic [CW-1:0]    sh_h_total, sh_h_act, sh_h_lead;
  logic [CW-1:0]    sh_v_total, sh_v_act, sh_v_lead;
  logic [RGB_W-1:0] sh_blank;

  logic [CW-1:0] ax_total [AXES];
  logic [CW-1:0] ax_lead  [AXES];
  logic [CW-1:0] ax_act   [AXES];
  logic [CW-1:0] ax_cnt   [AXES];
  logic [CW-1:0] ax_coord [AXES];
  logic          ax_last  [AXES];
  logic          ax_step  [AXES];
  logic          ax_sync  [AXES];
  logic          ax_in    [AXES];

  logic de_act;
  logic [FC_W-1:0] fcnt_d;

  assign en       = cfg_ctrl[CTRL_EN];
  assign pol_live = '{de_inv: cfg_ctrl[CTRL_DE_INV],
                      vs_inv: cfg_ctrl[CTRL_VS_INV],
                      hs_inv: cfg_ctrl[CTRL_HS_INV]};

  assign frame_end   = en & ax_last[AX_H] & ax_last[AX_V];
  assign shadow_load = ~en | frame_end;

  raster_shadow #(.CW(CW), .RGB_W(RGB_W)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (shadow_load),
    .h_total_i (cfg_total[CW-1:0]),
    .h_act_i   (cfg_active[CW-1:0]),
    .h_lead_i  (cfg_hporch[CW-1:0]),
    .v_total_i (cfg_total[W2-1:CW]),
    .v_act_i   (cfg_active[W2-1:CW]),
    .v_lead_i  (cfg_vporch[CW-1:0]),
    .blank_i   (cfg_blank),
    .pol_i     (pol_live),
    .h_total_o (sh_h_total),
    .h_act_o   (sh_h_act),
    .h_lead_o  (sh_h_lead),
    .v_total_o (sh_v_total),
    .v_act_o   (sh_v_act),
    .v_lead_o  (sh_v_lead),
    .blank_o   (sh_blank),
    .pol_o     (pol_sh)
  );

  assign ax_total[AX_H] = sh_h_total;
  assign ax_lead[AX_H]  = sh_h_lead;
  assign ax_act[AX_H]   = sh_h_act;
  assign ax_total[AX_V] = sh_v_total;
  assign ax_lead[AX_V]  = sh_v_lead;
  assign ax_act[AX_V]   = sh_v_act;

  assign ax_step[AX_H] = en;
  assign ax_step[AX_V] = en & ax_last[AX_H];

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    raster_axis_counter #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (~en),
      .step  (ax_step[a]),
      .total (ax_total[a]),
      .cnt   (ax_cnt[a]),
      .last  (ax_last[a])
    );

    raster_window #(.CW(CW)) u_win (
      .cnt    (ax_cnt[a]),
      .lead   (ax_lead[a]),
      .act    (ax_act[a]),
      .sync   (ax_sync[a]),
      .active (ax_in[a]),
      .coord  (ax_coord[a])
    );
  end

  // output decode
  always_comb begin
    de_act      = en & ax_in[AX_H] & ax_in[AX_V];
    hsync       = (en & ax_sync[AX_H]) ^ pol_sh.hs_inv;
    vsync       = (en & ax_sync[AX_V]) ^ pol_sh.vs_inv;
    de          = de_act ^ pol_sh.de_inv;
    pix_x       = de_act ? ax_coord[AX_H] : '0;
    pix_y       = de_act ? ax_coord[AX_V] : '0;
    frame_start = en & ax_sync[AX_H] & ax_sync[AX_V];
    if (!en) begin
      rgb_out = '0;
    end else if (de_act) begin
      rgb_out = pix_in;
    end else begin
      rgb_out = sh_blank;
    end
  end

  // frame counter
  always_comb begin
    fcnt_d = frame_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_cnt <= '0;
    end else if (frame_start) begin
      frame_cnt <= fcnt_d;
    end
  end

  AST_FCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (frame_cnt == FC_W'($past(frame_cnt) + 1'b1))); // R8

  AST_FCNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(frame_cnt)); // R8

  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (hsync == pol_sh.hs_inv && vsync == pol_sh.vs_inv &&
             de == pol_sh.de_inv && !frame_start)); // R7

  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !frame_end) |=> $stable({sh_h_total, sh_h_act, sh_h_lead,
                                    sh_v_total, sh_v_act, sh_v_lead, sh_blank, pol_sh})); // R9

  AST_SYNC_OUTSIDE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ax_sync[AX_H] || ax_sync[AX_V]) |-> !de_act); // R4
endmodule

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CW    = 16;
  localparam int RGB_W = 24;
  localparam int FCW   = 4;

  typedef struct packed {
    int ht; int ha; int hl; int htr;
    int vt; int va; int vl; int vtr;
    logic [23:0] blank;
    logic ih; logic iv; logic ide;
  } cfg_t;

  logic clk, rst_n;
  logic [2*CW-1:0] cfg_total, cfg_active, cfg_hporch, cfg_vporch;
  logic [RGB_W-1:0] cfg_blank, pix_in;
  logic [4:0] cfg_ctrl;
  logic hsync, vsync, de, frame_start;
  logic [CW-1:0] pix_x, pix_y;
  logic [RGB_W-1:0] rgb_out;
  logic [FCW-1:0] frame_cnt;

  int n_checks = 0;
  int n_err = 0;
  bit finished = 0;

  cfg_t cur, pend;
  bit pend_v;
  int mh, mv;
  int e_fc;

  raster_timing_gen #(.CW(CW), .RGB_W(RGB_W), .FC_W(FCW)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_total(cfg_total), .cfg_active(cfg_active),
    .cfg_hporch(cfg_hporch), .cfg_vporch(cfg_vporch),
    .cfg_blank(cfg_blank), .cfg_ctrl(cfg_ctrl), .pix_in(pix_in),
    .hsync(hsync), .vsync(vsync), .de(de),
    .pix_x(pix_x), .pix_y(pix_y), .rgb_out(rgb_out),
    .frame_start(frame_start), .frame_cnt(frame_cnt)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h (h=%0d v=%0d)", tag, act, exp, mh, mv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  endtask

  // R1: vertical in 31:16, horizontal in 15:0
  task automatic drive(input cfg_t c, input logic en);
    cfg_total  = {16'(c.vt),  16'(c.ht)};
    cfg_active = {16'(c.va),  16'(c.ha)};
    cfg_hporch = {16'(c.htr), 16'(c.hl)};
    cfg_vporch = {16'(c.vtr), 16'(c.vl)};
    cfg_blank  = c.blank;
    cfg_ctrl   = {c.ide, c.iv, c.ih, 1'b0, en};
  endtask

  task automatic check_cycle();
    logic hs_a, vs_a, hin, vin, de_a, fs;
    logic [31:0] ex_x, ex_y, ex_rgb;
    hs_a = (mh == 0);
    vs_a = (mv == 0);
    hin  = (mh >= cur.hl + 1) && (mh <= cur.hl + cur.ha);
    vin  = (mv >= cur.vl + 1) && (mv <= cur.vl + cur.va);
    de_a = hin && vin;
    fs   = hs_a && vs_a;
    ex_x   = de_a ? 32'(mh - cur.hl - 1) : 32'd0;
    ex_y   = de_a ? 32'(mv - cur.vl - 1) : 32'd0;
    ex_rgb = de_a ? {8'd0, pix_in} : {8'd0, cur.blank};
    chk("R1/R2/R6 hsync", {31'd0, hsync}, {31'd0, hs_a ^ cur.ih});
    chk("R3/R6 vsync", {31'd0, vsync}, {31'd0, vs_a ^ cur.iv});
    chk("R4/R6 de", {31'd0, de}, {31'd0, de_a ^ cur.ide});
    chk("R4 pix_x", {16'd0, pix_x}, ex_x);
    chk("R4 pix_y", {16'd0, pix_y}, ex_y);
    chk("R5 rgb_out", {8'd0, rgb_out}, ex_rgb);
    chk("R8 frame_start", {31'd0, frame_start}, {31'd0, fs});
    chk("R8 frame_cnt", {28'd0, frame_cnt}, 32'(e_fc));
  endtask

  task automatic advance();
    if (mh == 0 && mv == 0) e_fc = (e_fc + 1) % (1 << FCW);
    if (mh == cur.ht - 1) begin
      mh = 0;
      if (mv == cur.vt - 1) begin
        mv = 0;
        if (pend_v) begin cur = pend; pend_v = 0; end  // R9
      end else begin
        mv++;
      end
    end else begin
      mh++;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_in = 24'h3C5A00 ^ 24'(i * 7);
      #1;
      check_cycle();
      advance();
    end
  endtask

  task automatic check_idle(input cfg_t c);
    @(negedge clk);
    #1;
    chk("R7 hsync idle", {31'd0, hsync}, {31'd0, c.ih});
    chk("R7 vsync idle", {31'd0, vsync}, {31'd0, c.iv});
    chk("R7 de idle", {31'd0, de}, {31'd0, c.ide});
    chk("R7 rgb idle", {8'd0, rgb_out}, 32'd0);
    chk("R7 pix_x idle", {16'd0, pix_x}, 32'd0);
    chk("R7 frame_start idle", {31'd0, frame_start}, 32'd0);
    chk("R7 frame_cnt hold", {28'd0, frame_cnt}, 32'(e_fc));
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cfg_t ca, cb, cc;
    ca = '{ht:10, ha:4, hl:2, htr:3, vt:7, va:3, vl:1, vtr:2,
           blank:24'hFF00FF, ih:1'b0, iv:1'b0, ide:1'b0};
    cb = '{ht:4, ha:3, hl:0, htr:0, vt:3, va:2, vl:0, vtr:0,
           blank:24'h123456, ih:1'b1, iv:1'b1, ide:1'b1};
    cc = '{ht:287, ha:240, hl:2, htr:44, vt:325, va:320, vl:2, vtr:2,
           blank:24'h00A5C3, ih:1'b1, iv:1'b0, ide:1'b0};
    pend_v = 0;
    mh = 0; mv = 0; e_fc = 0;
    rst_n = 0;
    cfg_total = '0; cfg_active = '0; cfg_hporch = '0; cfg_vporch = '0;
    cfg_blank = '0; cfg_ctrl = '0; pix_in = '0;

    // R10: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R10 frame_cnt", {28'd0, frame_cnt}, 32'd0);
    chk("R10 hsync", {31'd0, hsync}, 32'd0);
    chk("R10 vsync", {31'd0, vsync}, 32'd0);
    chk("R10 de", {31'd0, de}, 32'd0);
    chk("R10 rgb", {8'd0, rgb_out}, 32'd0);
    chk("R10 frame_start", {31'd0, frame_start}, 32'd0);
    @(posedge clk);
    #1;
    rst_n = 1;

    // configuration A, then enable (R9: starts at pixel 0 of line 0)
    drive(ca, 1'b0);
    repeat (2) @(posedge clk);
    #1;
    drive(ca, 1'b1);
    cur = ca; mh = 0; mv = 0;
    run(75);

    // R9: mid-frame switch to configuration B
    @(posedge clk);
    #1;
    drive(cb, 1'b1);
    pend = cb; pend_v = 1;
    run(310);

    // R7: disable; configuration C picked up while idle
    @(posedge clk);
    #1;
    drive(cc, 1'b0);
    @(posedge clk);
    for (int i = 0; i < 4; i++) check_idle(cc);

    // enable C; counters must restart from zero
    @(posedge clk);
    #1;
    drive(cc, 1'b1);
    cur = cc; mh = 0; mv = 0; pend_v = 0;
    run(287 * 325 + 40);

    finish_run();
  end
endmodule